// File: doc/BRIEF.md
# Receive Timeslot-to-Channel Assigner

The block takes serial bit streams from several physical links, each arriving on its own link clock, and labels each received bit with the logical HDLC channel it belongs to. Its output is a single stream of (channel, bit, valid) in the system clock domain, which feeds a downstream HDLC engine. Line framing and clock recovery are done upstream. Each link supplies a data bit and a frame-start marker on the rising edge of its clock.

Each link is set up on its own as unchannelized, T1 channelized or E1 channelized. An unchannelized link sends every bit to one channel, taken from a per-link register. A channelized link counts bit positions inside 8-bit timeslots. A programmable per-link table then maps each timeslot to a channel number, or marks it to be dropped. Any set of timeslots, adjacent or not, may share one channel. Links of different modes can be mixed freely.

Each link crosses into the system clock through a toggle handshake. The crossing requires each link clock period to be at least 16 system clock periods. Pending bits from all links are then served round-robin, at most one per system cycle.

Top module: `ts_channel_assigner`

## Requirements
- R1: After reset, out_valid is 0. Every link is unchannelized with channel 0, and every table entry is disabled.
- R2: Configuration is written through the cfg port.
  - With cfg_sel=0, a write sets entry cfg_addr of link cfg_link. cfg_data[7] is the enable bit and cfg_data[6:0] is the channel.
  - With cfg_sel=1, a write sets the mode of link cfg_link from cfg_addr[1:0] (0 unchannelized, 1 T1, 2 E1, 3 treated as unchannelized). The same write sets the link's unchannelized channel from cfg_data[6:0].
- R3: In unchannelized mode, every bit received on the link is forwarded with the link's configured channel.
- R4: In T1 mode, each timeslot is 8 bits. Timeslots 0..23 use table entries 0..23. After the last bit of timeslot 23, the count wraps to timeslot 0 even without a frame-start.
- R5: In E1 mode, timeslots 0..31 are counted. Bits of timeslot 0 are always dropped, whatever its table entry holds. Timeslots 1..31 use table entries 1..31.
- R6: A bit whose timeslot entry has enable cleared produces no output.
- R7: A bit received with frame-start high is bit 0 of timeslot 0. The following bits count on from there.
- R8: Timeslots that are not adjacent may map to the same channel. That channel's bits come out in the order the link received them.
- R9: At most one bit is output per system cycle. Links are granted round-robin. When all links receive a bit at the same link edge, none of those bits is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk | input | 8 | Per-link receive clock; data is sampled on its rising edge |
| link_data | input | 8 | Per-link serial data bit |
| link_fs | input | 8 | Per-link frame-start marker, sampled with the data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects a table entry, 1 selects the link mode register |
| cfg_link | input | 3 | Link addressed by the write |
| cfg_addr | input | 5 | Timeslot index, or the mode in bits [1:0] |
| cfg_data | input | 8 | Table entry {enable, channel}, or the unchannelized channel in [6:0] |
| out_valid | output | 1 | An output bit is present this cycle |
| out_chan | output | 7 | Channel of the output bit |
| out_bit | output | 1 | Output data bit |

## Verification
The bench goes after these corner cases:

- **E1 timeslot 0 with an enabled table entry.** A design that consulted the table there would emit unexpected bits on that channel.
- **T1 rollover without a frame-start.** A counter that ran to 32 would put the second frame's bits on the wrong channels.
- **Frame-start arriving mid-timeslot.** A design that did not restart the count would misassign every bit after it.
- **Noncontiguous slots sharing a channel.** Per-channel ordered comparison exposes any reordering or dropped bits.
- **All eight links delivering at once.** An arbiter that starved a link or let a pending bit be overwritten would leave expected bits unconsumed.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [1:0] {
    MODE_UNCH = 2'd0,
    MODE_T1   = 2'd1,
    MODE_E1   = 2'd2,
    MODE_RSV  = 2'd3
  } link_mode_e;

  localparam int T1_SLOTS = 24;
  localparam int E1_SLOTS = 32;

  typedef struct packed {
    logic [2:0] bitpos;
    logic [4:0] slot;
  } slot_pos_t;

  function automatic logic is_channelized(link_mode_e m);
    return (m == MODE_T1) || (m == MODE_E1);
  endfunction

  function automatic logic [4:0] last_slot(link_mode_e m);
    return (m == MODE_T1) ? 5'(T1_SLOTS - 1) : 5'(E1_SLOTS - 1);
  endfunction

  // position of the bit after the one at p
  function automatic slot_pos_t advance(slot_pos_t p, link_mode_e m);
    slot_pos_t n;
    if (p.bitpos != 3'd7) begin
      n.bitpos = p.bitpos + 3'd1;
      n.slot   = p.slot;
    end else begin
      n.bitpos = 3'd0;
      n.slot   = (p.slot >= last_slot(m)) ? 5'd0 : p.slot + 5'd1;
    end
    return n;
  endfunction

  // does a bit in slot s survive, given the table enable for s
  function automatic logic slot_kept(link_mode_e m, logic [4:0] s, logic tab_en);
    if (!is_channelized(m)) return 1'b1;
    if (m == MODE_E1 && s == 5'd0) return 1'b0;
    return tab_en;
  endfunction
endpackage

// File: rtl/tsa_link_sync.sv
module tsa_link_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic link_clk,
  input  logic link_data,
  input  logic link_fs,
  output logic stb,
  output logic bit_out,
  output logic fs_out
);
  logic l_bit, l_fs, l_tog;
  logic s1, s2, s3;

  always_ff @(posedge link_clk or negedge rst_n) begin
    if (!rst_n) begin
      l_bit <= 1'b0;
      l_fs  <= 1'b0;
      l_tog <= 1'b0;
    end else begin
      l_bit <= link_data;
      l_fs  <= link_fs;
      l_tog <= ~l_tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= l_tog;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // captured data has been stable for several system cycles when the toggle lands
  assign stb     = s2 ^ s3;
  assign bit_out = l_bit;
  assign fs_out  = l_fs;
endmodule

// File: rtl/tsa_slot_mapper.sv
module tsa_slot_mapper
  import tsa_pkg::*;
#(
  parameter int CHAN_W = 7,
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              bit_in,
  input  logic              fs_in,
  input  logic              we_tab,
  input  logic              we_link,
  input  logic [SLOT_W-1:0] cfg_addr,
  input  logic [CHAN_W:0]   cfg_data,
  input  logic              clr,
  output logic              pend,
  output logic [CHAN_W-1:0] pend_chan,
  output logic              pend_bit
);
  logic [SLOTS-1:0]  tab_en;
  logic [CHAN_W-1:0] tab_ch [SLOTS];
  link_mode_e        mode;
  logic [CHAN_W-1:0] uchan;
  slot_pos_t         pos_q, cur_pos;
  logic              keep;
  logic [CHAN_W-1:0] sel_chan;

  assign cur_pos  = fs_in ? '0 : pos_q;
  assign keep     = slot_kept(mode, cur_pos.slot, tab_en[cur_pos.slot]);
  assign sel_chan = is_channelized(mode) ? tab_ch[cur_pos.slot] : uchan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab_en <= '0;
      for (int i = 0; i < SLOTS; i++) tab_ch[i] <= '0;
      mode  <= MODE_UNCH;
      uchan <= '0;
    end else begin
      if (we_tab) begin
        tab_en[cfg_addr] <= cfg_data[CHAN_W];
        tab_ch[cfg_addr] <= cfg_data[CHAN_W-1:0];
      end
      if (we_link) begin
        mode  <= link_mode_e'(cfg_addr[1:0]);
        uchan <= cfg_data[CHAN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      pend      <= 1'b0;
      pend_chan <= '0;
      pend_bit  <= 1'b0;
    end else begin
      if (stb) pos_q <= advance(cur_pos, mode);
      if (stb && keep) begin
        pend      <= 1'b1;
        pend_chan <= sel_chan;
        pend_bit  <= bit_in;
      end else if (clr) begin
        pend <= 1'b0;
      end
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && keep && pend && !clr));
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
  // R5
  e1_slot0_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && mode == MODE_E1 && cur_pos.slot == 5'd0 && !pend) |=> !pend);
  // R7
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && fs_in) |=> (pos_q.bitpos == 3'd1 && pos_q.slot == 5'd0));
endmodule

// File: rtl/tsa_rr_arbiter.sv
module tsa_rr_arbiter #(
  parameter int N      = 8,
  parameter int CHAN_W = 7,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        req,
  input  logic [N*CHAN_W-1:0] chan_flat,
  input  logic [N-1:0]        bits,
  output logic [N-1:0]        gnt,
  output logic                out_valid,
  output logic [CHAN_W-1:0]   out_chan,
  output logic                out_bit
);
  logic [IDX_W-1:0] ptr, sel;
  logic             found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int off = 0; off < N; off++) begin
      int k;
      k = (int'(ptr) + off) % N;
      if (!found && req[k]) begin
        found = 1'b1;
        sel   = IDX_W'(k);
      end
    end
    gnt = found ? (N'(1) << sel) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= found;
      if (found) begin
        out_chan <= chan_flat[sel*CHAN_W +: CHAN_W];
        out_bit  <= bits[sel];
        ptr      <= (int'(sel) == N - 1) ? '0 : sel + IDX_W'(1);
      end
    end
  end

  // R9
  rr_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) != '0 && (req & ~$past(gnt)) != '0) |-> ((gnt & $past(gnt)) == '0));
  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/ts_channel_assigner.sv
module ts_channel_assigner #(
  parameter int NUM_LINKS = 8,
  parameter int CHAN_W    = 7,
  parameter int SLOTS     = 32,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] link_clk,
  input  logic [NUM_LINKS-1:0] link_data,
  input  logic [NUM_LINKS-1:0] link_fs,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [LINK_W-1:0]    cfg_link,
  input  logic [SLOT_W-1:0]    cfg_addr,
  input  logic [CHAN_W:0]      cfg_data,
  output logic                 out_valid,
  output logic [CHAN_W-1:0]    out_chan,
  output logic                 out_bit
);
  logic [NUM_LINKS-1:0]        stb, s_bit, s_fs, pend, pbit, gnt;
  logic [NUM_LINKS*CHAN_W-1:0] pchan;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    logic sel_me;
    assign sel_me = cfg_we && (int'(cfg_link) == i);

    tsa_link_sync u_sync (
      .clk(clk), .rst_n(rst_n),
      .link_clk(link_clk[i]), .link_data(link_data[i]), .link_fs(link_fs[i]),
      .stb(stb[i]), .bit_out(s_bit[i]), .fs_out(s_fs[i])
    );

    tsa_slot_mapper #(.CHAN_W(CHAN_W), .SLOTS(SLOTS)) u_map (
      .clk(clk), .rst_n(rst_n),
      .stb(stb[i]), .bit_in(s_bit[i]), .fs_in(s_fs[i]),
      .we_tab(sel_me && !cfg_sel), .we_link(sel_me && cfg_sel),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .clr(gnt[i]),
      .pend(pend[i]), .pend_chan(pchan[i*CHAN_W +: CHAN_W]), .pend_bit(pbit[i])
    );
  end

  tsa_rr_arbiter #(.N(NUM_LINKS), .CHAN_W(CHAN_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(pend), .chan_flat(pchan), .bits(pbit), .gnt(gnt),
    .out_valid(out_valid), .out_chan(out_chan), .out_bit(out_bit)
  );
endmodule

// File: tb/ts_channel_assigner_bench.sv
module ts_channel_assigner_bench;
  localparam int CLK_NS = 10;
  localparam int NL = 8;

  logic          clk = 0, rst_n = 0;
  logic [NL-1:0] link_clk = '0, link_data = '0, link_fs = '0;
  logic          cfg_we = 0, cfg_sel = 0;
  logic [2:0]    cfg_link = '0;
  logic [4:0]    cfg_addr = '0;
  logic [7:0]    cfg_data = '0;
  logic          out_valid, out_bit;
  logic [6:0]    out_chan;

  ts_channel_assigner u_ts_channel_assigner (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_data(link_data),
    .link_fs(link_fs), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_link(cfg_link),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .out_valid(out_valid),
    .out_chan(out_chan), .out_bit(out_bit)
  );

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0, errors = 0;
  int cycles = 0;

  // bench model of configuration and position
  logic [1:0] m_mode [NL];
  logic [6:0] m_uch  [NL];
  logic       m_en   [NL][32];
  logic [6:0] m_ch   [NL][32];
  int         m_bit  [NL];
  int         m_slot [NL];

  // expected bits per channel
  logic exp_q [128][512];
  int   wr_i [128];
  int   rd_i [128];
  logic [15:0] lf = 16'hACE1;

  // output monitor (R8: per-channel order)
  always @(negedge clk) begin
    cycles++;
    if (rst_n && out_valid) begin
      vectors++;
      if (rd_i[out_chan] == wr_i[out_chan]) begin
        errors++;
        $display("FAIL R6/R3: unexpected bit on channel %0d actual valid=1 expected no output", out_chan);
      end else begin
        if (exp_q[out_chan][rd_i[out_chan] % 512] !== out_bit) begin
          errors++;
          $display("FAIL R8: channel %0d bit #%0d actual %0b expected %0b", out_chan,
                   rd_i[out_chan], out_bit, exp_q[out_chan][rd_i[out_chan] % 512]);
        end
        rd_i[out_chan]++;
      end
    end
  end

  task automatic cfg_write(input logic sel, input int lk, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_link = 3'(lk); cfg_addr = 5'(addr); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 0;
    if (sel) begin m_mode[lk] = 2'(addr); m_uch[lk] = 7'(data); end
    else begin m_en[lk][addr] = data[7]; m_ch[lk][addr] = 7'(data); end
  endtask

  function automatic int lastslot(int lk);
    return (m_mode[lk] == 2'd1) ? 23 : 31;
  endfunction

  // one link edge on every link in mask
  task automatic send(input logic [NL-1:0] mask, input logic [NL-1:0] fsm);
    for (int i = 0; i < NL; i++) begin
      if (mask[i]) begin
        int b, s;
        logic chz, kp, d;
        logic [6:0] ch;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        d = lf[i % 16] ^ lf[(i + 5) % 16];
        link_data[i] = d;
        link_fs[i] = fsm[i];
        b = fsm[i] ? 0 : m_bit[i];
        s = fsm[i] ? 0 : m_slot[i];
        chz = (m_mode[i] == 2'd1) || (m_mode[i] == 2'd2);
        if (!chz) begin kp = 1; ch = m_uch[i]; end
        else if (m_mode[i] == 2'd2 && s == 0) begin kp = 0; ch = 0; end
        else begin kp = m_en[i][s]; ch = m_ch[i][s]; end
        if (kp) begin exp_q[ch][wr_i[ch] % 512] = d; wr_i[ch]++; end
        if (b == 7) begin b = 0; s = (s >= lastslot(i)) ? 0 : s + 1; end
        else b = b + 1;
        m_bit[i] = b; m_slot[i] = s;
      end
    end
    #40 link_clk = link_clk | mask;
    #40 link_clk = link_clk & ~mask;
    link_fs = '0;
    #120;
  endtask

  task automatic drain_check(input string tag);
    int bad;
    bad = 0;
    repeat (40) @(negedge clk);
    for (int c = 0; c < 128; c++) if (rd_i[c] != wr_i[c]) begin
      bad++;
      $display("FAIL %s: channel %0d delivered %0d bits expected %0d", tag, c, rd_i[c], wr_i[c]);
    end
    vectors++;
    if (bad != 0) errors++;
  endtask

  task automatic t_reset;
    // R1
    vectors++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: out_valid actual %0b expected 0", out_valid);
    end
    // R1: default unchannelized channel 0, no config written
    send(8'h01, 8'h00); send(8'h01, 8'h00);
    drain_check("R1");
  endtask

  task automatic t_unch;
    // R3, R2
    cfg_write(1, 0, 0, 5);
    for (int k = 0; k < 20; k++) send(8'h01, 8'h00);
    drain_check("R3");
  endtask

  task automatic t_t1;
    // R4, R6, R8: slots 3,7,20 -> ch 10, slot 5 -> ch 11, rest disabled
    cfg_write(1, 1, 1, 0);
    cfg_write(0, 1, 3, 8'h80 | 10);
    cfg_write(0, 1, 7, 8'h80 | 10);
    cfg_write(0, 1, 20, 8'h80 | 10);
    cfg_write(0, 1, 5, 8'h80 | 11);
    cfg_write(0, 1, 6, 12);
    send(8'h02, 8'h02);
    for (int k = 1; k < 24 * 8 + 64; k++) send(8'h02, 8'h00);
    drain_check("R4");
  endtask

  task automatic t_e1;
    // R5: slot 0 enabled in table but must be dropped; R7 mid-frame restart
    cfg_write(1, 2, 2, 0);
    cfg_write(0, 2, 0, 8'h80 | 20);
    cfg_write(0, 2, 1, 8'h80 | 21);
    cfg_write(0, 2, 31, 8'h80 | 21);
    cfg_write(0, 2, 16, 8'h80 | 22);
    send(8'h04, 8'h04);
    for (int k = 1; k < 32 * 8 + 8; k++) send(8'h04, 8'h00);
    drain_check("R5");
    for (int k = 0; k < 13; k++) send(8'h04, 8'h00);
    send(8'h04, 8'h04);
    for (int k = 1; k < 20; k++) send(8'h04, 8'h00);
    drain_check("R7");
  endtask

  task automatic t_all;
    // R9: all links at once, mixed modes, distinct channel per link
    for (int l = 0; l < NL; l++) begin
      int md;
      md = (l % 2 == 0) ? 0 : ((l == 1 || l == 3) ? 1 : 2);
      cfg_write(1, l, md, 40 + l);
      if (md != 0) for (int s = 0; s < 32; s++) cfg_write(0, l, s, 8'h80 | (40 + l));
    end
    send(8'hFF, 8'hFF);
    for (int k = 1; k < 300; k++) send(8'hFF, 8'h00);
    drain_check("R9");
  endtask

  initial begin
    for (int c = 0; c < 128; c++) begin wr_i[c] = 0; rd_i[c] = 0; end
    for (int l = 0; l < NL; l++) begin
      m_mode[l] = 0; m_uch[l] = 0; m_bit[l] = 0; m_slot[l] = 0;
      for (int s = 0; s < 32; s++) begin m_en[l][s] = 0; m_ch[l][s] = 0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unch();
    t_t1();
    t_e1();
    t_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++;
    $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule